// File: doc/BRIEF.md
# Dual Edge-Selectable Capture Unit

This block timestamps transitions on external signals. It holds two identical capture channels. Each channel passes its pin through a two-flop synchronizer and watches the synchronized level for the transition kind that its 2-bit mode selects. When that transition is seen, the channel copies the free-running counter value supplied by the surrounding timer into its own capture register and raises its capture flag.

A raised flag drives the channel's interrupt line only while that channel's interrupt enable is high. Software clears the flag by writing a one, which reaches the block as a single-cycle clear strobe per channel.

The mode fields of both channels share one control word, 2 bits per channel. All channel logic is built from one parameterized channel path, repeated by a generate loop.

Top module: `edge_capture_pair`

## Requirements
- R1: After reset, every capture value is 0 and every flag and interrupt output is 0.
- R2: Channel 0 takes its mode from control bits [1:0] and channel 1 from bits [3:2]. Mode code 0 disables capture, 1 selects rising transitions, 2 selects falling transitions and 3 selects both.
- R3: In mode 1 a low-to-high pin change causes a capture, and a high-to-low change causes none.
- R4: In mode 2 a high-to-low pin change causes a capture, and a low-to-high change causes none.
- R5: In mode 3 pin changes in either direction cause a capture.
- R6: In mode 0 no capture takes place, the flag does not rise, and the last captured value is kept.
- R7: Take the first rising clock edge at which the pin holds its new level. The capture happens at the third rising clock edge counted from that one. It stores the counter value present at that third edge, and the flag rises at that same edge.
- R8: A high clear strobe lowers the flag at the next clock edge. If a capture and a clear strobe fall in the same cycle, the flag stays set.
- R9: A new capture overwrites the capture value even while the flag is still set.
- R10: A channel's interrupt output is high exactly when its flag and its interrupt enable are both high.
- R11: The two channels are independent. A pin change, mode or clear on one channel leaves the other channel's value and flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | NCH | Asynchronous capture pins, one per channel |
| count_i | input | CW | Timer counter value to be captured |
| mode_word_i | input | 2*NCH | Packed 2-bit edge modes, channel 0 in the lowest field |
| irq_en_i | input | NCH | Per-channel interrupt enable |
| flag_clr_i | input | NCH | Per-channel write-one-to-clear strobe for the flag |
| cap_val_o | output | NCH*CW | Captured counter values, channel c in bits [c*CW +: CW] |
| flag_o | output | NCH | Per-channel capture flag |
| irq_o | output | NCH | Per-channel interrupt request |

## Verification
The bench changes the counter value just before the third clock edge and samples the flag one cycle earlier than that edge. A design with one synchronizer stage too few or too many would therefore show an early flag or store the wrong counter value. Each mode is driven with transitions that it must ignore. A swapped rising/falling qualification, or a wrong decode of the mode code, would then load the register when it should not. The bench also raises the clear strobe in the very cycle of a capture, where a design that gives the clear priority would drop the flag. A last test drives one channel's pin while only the other channel's field is enabled, which exposes a swapped mode field.

// File: rtl/edge_cap_pkg.sv
package edge_cap_pkg;
  localparam int MODE_W = 2;

  // bit 0 qualifies low-to-high, bit 1 qualifies high-to-low
  typedef enum logic [MODE_W-1:0] {
    CAP_OFF  = 2'd0,
    CAP_RISE = 2'd1,
    CAP_FALL = 2'd2,
    CAP_ANY  = 2'd3
  } cap_mode_e;
endpackage

// File: rtl/edge_cap_rst_sync.sv
module edge_cap_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/edge_cap_sync.sv
module edge_cap_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], d_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/edge_cap_detect.sv
module edge_cap_detect
  import edge_cap_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      smp_i,
  input  cap_mode_e mode_i,
  output logic      hit_o
);
  logic prev_q;
  logic prev_d;
  logic rise;
  logic fall;

  always_comb begin
    prev_d = smp_i;
    rise   = smp_i & ~prev_q;
    fall   = ~smp_i & prev_q;
    hit_o  = (rise & mode_i[0]) | (fall & mode_i[1]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end
endmodule

// File: rtl/edge_cap_channel.sv
module edge_cap_channel #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hit_i,
  input  logic [CW-1:0] count_i,
  input  logic          clr_i,
  input  logic          irq_en_i,
  output logic [CW-1:0] value_o,
  output logic          flag_o,
  output logic          irq_o
);
  logic [CW-1:0] value_q;
  logic [CW-1:0] value_d;
  logic          value_en;
  logic          flag_q;
  logic          flag_d;
  logic          flag_en;

  always_comb begin
    value_en = hit_i;
    value_d  = count_i;
    // a capture wins over a simultaneous clear
    flag_en  = hit_i | clr_i;
    flag_d   = hit_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        value_q <= '0;
    else if (value_en) value_q <= value_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign value_o = value_q;
  assign flag_o  = flag_q;
  assign irq_o   = flag_q & irq_en_i;
endmodule

// File: rtl/edge_capture_pair.sv
module edge_capture_pair
  import edge_cap_pkg::*;
#(
  parameter int NCH      = 2,
  parameter int CW       = 16,
  parameter int SYNC_LEN = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        pin_i,
  input  logic [CW-1:0]         count_i,
  input  logic [MODE_W*NCH-1:0] mode_word_i,
  input  logic [NCH-1:0]        irq_en_i,
  input  logic [NCH-1:0]        flag_clr_i,
  output logic [NCH*CW-1:0]     cap_val_o,
  output logic [NCH-1:0]        flag_o,
  output logic [NCH-1:0]        irq_o
);
  logic rst_n_int;

  edge_cap_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic      pin_s;
    logic      hit;
    cap_mode_e mode;

    assign mode = cap_mode_e'(mode_word_i[c*MODE_W +: MODE_W]);

    edge_cap_sync #(.STAGES(SYNC_LEN)) u_sync (
      .clk   (clk),
      .rst_n (rst_n_int),
      .d_i   (pin_i[c]),
      .q_o   (pin_s)
    );

    edge_cap_detect u_det (
      .clk    (clk),
      .rst_n  (rst_n_int),
      .smp_i  (pin_s),
      .mode_i (mode),
      .hit_o  (hit)
    );

    edge_cap_channel #(.CW(CW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n_int),
      .hit_i    (hit),
      .count_i  (count_i),
      .clr_i    (flag_clr_i[c]),
      .irq_en_i (irq_en_i[c]),
      .value_o  (cap_val_o[c*CW +: CW]),
      .flag_o   (flag_o[c]),
      .irq_o    (irq_o[c])
    );
  end
endmodule

// File: rtl/edge_capture_pair_chk.sv
module edge_capture_pair_chk #(
  parameter int NCH = 2,
  parameter int CW  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic [2*NCH-1:0]  mode_word_i,
  input logic [NCH-1:0]    irq_en_i,
  input logic [NCH-1:0]    flag_clr_i,
  input logic [NCH*CW-1:0] cap_val_o,
  input logic [NCH-1:0]    flag_o,
  input logic [NCH-1:0]    irq_o
);
  for (genvar c = 0; c < NCH; c++) begin : g_chk
    assert_off_keeps_value_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_word_i[2*c +: 2] == 2'd0) |=> $stable(cap_val_o[c*CW +: CW]));

    assert_off_no_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_word_i[2*c +: 2] == 2'd0) |=> !$rose(flag_o[c]));

    assert_irq_needs_enable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_en_i[c] |-> !irq_o[c]);

    assert_irq_needs_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o[c] |-> flag_o[c]);

    assert_load_sets_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(cap_val_o[c*CW +: CW]) |-> flag_o[c]);

    assert_clear_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_o[c] && flag_clr_i[c] && mode_word_i[2*c +: 2] == 2'd0) |=> !flag_o[c]);
  end
endmodule

bind edge_capture_pair edge_capture_pair_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .mode_word_i (mode_word_i),
  .irq_en_i    (irq_en_i),
  .flag_clr_i  (flag_clr_i),
  .cap_val_o   (cap_val_o),
  .flag_o      (flag_o),
  .irq_o       (irq_o)
);

// File: tb/edge_capture_pair_bench.sv
module edge_capture_pair_bench;
  localparam int NCH = 2;
  localparam int CW  = 16;

  logic              clk;
  logic              rst_n;
  logic [NCH-1:0]    pin;
  logic [CW-1:0]     count;
  logic [2*NCH-1:0]  mode_w;
  logic [NCH-1:0]    irq_en;
  logic [NCH-1:0]    clr;
  logic [NCH*CW-1:0] cap;
  logic [NCH-1:0]    flag;
  logic [NCH-1:0]    irq;

  int total = 0;
  int bad   = 0;

  edge_capture_pair #(.NCH(NCH), .CW(CW)) u_edge_capture_pair (
    .clk         (clk),
    .rst_n       (rst_n),
    .pin_i       (pin),
    .count_i     (count),
    .mode_word_i (mode_w),
    .irq_en_i    (irq_en),
    .flag_clr_i  (clr),
    .cap_val_o   (cap),
    .flag_o      (flag),
    .irq_o       (irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [CW-1:0] val_of(input int ch);
    return cap[ch*CW +: CW];
  endfunction

  // change pin, put val on the counter for the third edge, optionally clear in that cycle
  task automatic pin_edge(input int ch, input logic lvl, input logic [CW-1:0] val,
                          input logic clr_same, input bit chk_early);
    @(negedge clk); pin[ch] = lvl; count = 16'hDEAD;
    @(negedge clk);
    @(negedge clk);
    if (chk_early) chk("R7 flag low before third edge", flag[ch], 1'b0);
    count = val;
    if (clr_same) clr[ch] = 1'b1;
    @(negedge clk); clr[ch] = 1'b0; count = 16'hBEEF;
  endtask

  task automatic clear_flag(input int ch);
    @(negedge clk); clr[ch] = 1'b1;
    @(negedge clk); clr[ch] = 1'b0;
  endtask

  task automatic t_reset;
    chk("R1 value ch0 after reset", val_of(0), 0);
    chk("R1 value ch1 after reset", val_of(1), 0);
    chk("R1 flags after reset", flag, 0);
    chk("R1 irq after reset", irq, 0);
  endtask

  task automatic t_rise;
    mode_w = 4'b0001;
    pin_edge(0, 1'b1, 16'h0011, 1'b0, 1'b1);
    chk("R7 flag at third edge", flag[0], 1'b1);
    chk("R3 R7 rising captures counter", val_of(0), 16'h0011);
    clear_flag(0);
    chk("R8 clear lowers flag", flag[0], 1'b0);
    pin_edge(0, 1'b0, 16'h0022, 1'b0, 1'b0);
    chk("R3 falling ignored in rise mode flag", flag[0], 1'b0);
    chk("R3 falling ignored in rise mode value", val_of(0), 16'h0011);
  endtask

  task automatic t_fall;
    mode_w = 4'b0010;
    pin_edge(0, 1'b1, 16'h0033, 1'b0, 1'b0);
    chk("R4 rising ignored in fall mode", val_of(0), 16'h0011);
    chk("R4 rising ignored flag", flag[0], 1'b0);
    pin_edge(0, 1'b0, 16'h0044, 1'b0, 1'b1);
    chk("R4 falling captures", val_of(0), 16'h0044);
    chk("R4 falling sets flag", flag[0], 1'b1);
    clear_flag(0);
  endtask

  task automatic t_both;
    mode_w = 4'b0011;
    pin_edge(0, 1'b1, 16'h0055, 1'b0, 1'b1);
    chk("R5 rising captures in both mode", val_of(0), 16'h0055);
    pin_edge(0, 1'b0, 16'h0066, 1'b0, 1'b0);
    chk("R9 R5 falling overwrites while flag set", val_of(0), 16'h0066);
    chk("R9 flag still set", flag[0], 1'b1);
  endtask

  task automatic t_irq;
    @(negedge clk); irq_en[0] = 1'b0; #1;
    chk("R10 irq low when disabled", irq[0], 1'b0);
    irq_en[0] = 1'b1; #1;
    chk("R10 irq high with flag and enable", irq[0], 1'b1);
    clear_flag(0);
    chk("R10 irq drops with flag", irq[0], 1'b0);
    irq_en[0] = 1'b0;
  endtask

  task automatic t_off;
    mode_w = 4'b0000;
    pin_edge(0, 1'b1, 16'h0077, 1'b0, 1'b0);
    pin_edge(0, 1'b0, 16'h0088, 1'b0, 1'b0);
    chk("R6 disabled keeps value", val_of(0), 16'h0066);
    chk("R6 disabled no flag", flag[0], 1'b0);
  endtask

  task automatic t_cap_and_clear;
    mode_w = 4'b0011;
    pin_edge(0, 1'b1, 16'h0099, 1'b1, 1'b1);
    chk("R8 capture beats clear flag", flag[0], 1'b1);
    chk("R8 capture beats clear value", val_of(0), 16'h0099);
    clear_flag(0);
  endtask

  task automatic t_ch1;
    mode_w = 4'b0100;
    pin_edge(1, 1'b1, 16'h00AA, 1'b0, 1'b1);
    chk("R2 ch1 field bits 3:2 rising", val_of(1), 16'h00AA);
    chk("R11 ch1 flag set", flag[1], 1'b1);
    chk("R11 ch0 flag untouched", flag[0], 1'b0);
    chk("R11 ch0 value untouched", val_of(0), 16'h0099);
    clear_flag(1);
    mode_w = 4'b0001;
    pin_edge(1, 1'b0, 16'h00BB, 1'b0, 1'b0);
    pin_edge(1, 1'b1, 16'h00CC, 1'b0, 1'b0);
    chk("R2 ch0 field does not drive ch1", val_of(1), 16'h00AA);
    chk("R2 ch1 flag stays low", flag[1], 1'b0);
    chk("R11 ch0 ignores ch1 pin", flag[0], 1'b0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; pin = '0; count = '0; mode_w = '0; irq_en = '0; clr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rise();
    t_fall();
    t_both();
    t_irq();
    t_off();
    t_cap_and_clear();
    t_ch1();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule